// File: doc/BRIEF.md
# Dual card slot control registers

This block is the host-facing control register file for two common-interface card slots. A host reaches it through an indexed byte-wide register bus, with a 4-bit index, a write strobe, a read strobe and a combinational read word. Through these registers the host can set up a 15-bit card address and choose the target slot and address space. It can then issue card data reads and writes, start a timed reset of either slot, steer each slot's transport stream through its card, and drive the tuner reset lines and the TS output enables.

Each slot has an active-low card-detect input. The block passes it through a two-flop synchronizer, shows it in the bus control register and watches it for changes. A change latches a per-slot pending flag. An active-low interrupt line is low while any pending flag has its enable set. Reading the interrupt register clears the pending flags. Strobe timing toward the card and the TS datapath live elsewhere: this block only issues one-cycle read and write requests, together with the address, slot and space.

A slot reset runs in two phases. First the slot's reset output is held high for a fixed number of cycles. Then the block waits for that slot's ready input, giving up after a bounded number of cycles. The busy bit the host reads is set for both phases and clears itself at the end.

Top module: `ci_dual_slot_regs`

## Requirements
- R1: After reset, slot_rst, ts_route, ts_out_en and tuner_rst_n are all 0 and irq_n is 1. The interrupt register (index 0x0) reads 0x00, and with both card_det_n inputs high the bus control register (index 0x7) reads 0x03.
- R2: A write to index 0x4 stores bits 7..1 and reads back with bit 0 forced to 0. A write to index 0x5 stores bits 6..0 and reads back with bit 7 at 0. card_addr equals {index 0x5 bits 6..0, index 0x4 bits 7..1, 0}.
- R3: Bus control bit 7 drives card_sel (slot number) and bit 6 drives card_io_space (1 = control space, 0 = attribute memory). An access to index 0x6 raises card_wr for a write, or card_rd for a read, in that same cycle. card_wdata follows reg_wdata, and a read of index 0x6 returns card_rdata.
- R4: Writing 1 to bus control bit (5 - s) while slot s is idle raises slot_rst[s] from the next cycle for exactly RST_CYCLES cycles. Bit (5 - s) reads 1 from the next cycle until the sequence ends.
- R5: After the pulse, slot s waits for card_rdy[s]. If card_rdy[s] is already high, busy lasts RST_CYCLES + 1 cycles in total. If card_rdy[s] stays low, busy clears after RST_CYCLES + TIMEOUT_CYCLES cycles in total.
- R6: While a slot is busy, writing 1 to its reset bit does not restart the sequence, and writing 0 does not abort it.
- R7: Bus control bit (3 - s) is a read/write bit that drives ts_route[s].
- R8: Bus control bit (1 - s) reads card_det_n[s] delayed by two clock edges. Writes to bits 1..0 have no effect.
- R9: A change of a synchronized detect bit of slot s sets that slot's pending flag on the next edge. irq_n is low while a pending flag has its enable set. Writing 0x44 to index 0x0 sets both enables (bit 6 for slot 0, bit 2 for slot 1).
- R10: The interrupt register reads pending slot 0 at bit 7, enable 0 at bit 6, pending slot 1 at bit 3 and enable 1 at bit 2. A read of it clears both pending flags on the next edge, except that a change arriving in the same cycle sets its flag.
- R11: Index 0x1 bits 5 and 4 drive ts_out_en[1] and ts_out_en[0]. Bit (3 - s) drives tuner_rst_n[s] (0 holds the tuner in reset). The other bits of index 0x1 read 0.
- R12: Index 0xF reads the REVISION parameter. Indices 0x2, 0x3 and 0x8 to 0xE read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read word of the indexed register |
| card_det_n | input | 2 | Active-low card detect, one per slot |
| card_rdy | input | 2 | Card ready after reset, one per slot |
| card_rdata | input | 8 | Data returned by the card for a read |
| slot_rst | output | 2 | Slot reset pulses |
| ts_route | output | 2 | Route slot TS through its card |
| ts_out_en | output | 2 | TS output enables |
| tuner_rst_n | output | 2 | Active-low tuner resets |
| card_addr | output | 15 | Card byte address |
| card_sel | output | 1 | Target slot of a card access |
| card_io_space | output | 1 | 1 = control space, 0 = attribute memory |
| card_wr | output | 1 | Card write request |
| card_rd | output | 1 | Card read request |
| card_wdata | output | 8 | Card write data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bound checker watches the reset sequencer and the interrupt flags on every cycle. An accepted start must open a pulse, a pulse implies busy, the wait phase never falls back into a pulse, and a wait never outlasts its timeout. A detect change must set its pending flag and pull irq_n low when enabled, and an acknowledge must clear a flag that no new change is setting. The exact pulse and timeout lengths, the bit positions of every field, the detect latency and the change-versus-acknowledge collision are shown only by the bench's scenarios against its reference model.

// File: rtl/ci_slot_pkg.sv
package ci_slot_pkg;

  localparam int SLOT_COUNT = 2;

  // register indices
  localparam logic [3:0] IDX_IRQ     = 4'h0;
  localparam logic [3:0] IDX_CTL2    = 4'h1;
  localparam logic [3:0] IDX_ADDR_LO = 4'h4;
  localparam logic [3:0] IDX_ADDR_HI = 4'h5;
  localparam logic [3:0] IDX_DATA    = 4'h6;
  localparam logic [3:0] IDX_CTL     = 4'h7;
  localparam logic [3:0] IDX_REV     = 4'hF;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PULSE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;

  // bit positions inside the bus control register
  function automatic int rst_bit(input int s);
    return 5 - s;
  endfunction

  function automatic int route_bit(input int s);
    return 3 - s;
  endfunction

  function automatic int det_bit(input int s);
    return 1 - s;
  endfunction

  // bit positions inside bus control 2
  function automatic int tuner_bit(input int s);
    return 3 - s;
  endfunction

  function automatic int tsen_bit(input int s);
    return 4 + s;
  endfunction

  // bit positions inside the interrupt register
  function automatic int irq_en_bit(input int s);
    return 6 - 4 * s;
  endfunction

  function automatic int irq_pend_bit(input int s);
    return 7 - 4 * s;
  endfunction

  // card byte address from the stored low (bits 7..1) and high fields
  function automatic logic [14:0] join_card_addr(input logic [6:0] lo_field,
                                                 input logic [6:0] hi_field);
    return {hi_field, lo_field, 1'b0};
  endfunction

endpackage

// File: rtl/ci_det_sync.sv
module ci_det_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic det_n,
  output logic det_sync,
  output logic change
);

  logic stage1, stage2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b1;
      stage2 <= 1'b1;
      prev   <= 1'b1;
    end else begin
      stage1 <= det_n;
      stage2 <= stage1;
      prev   <= stage2;
    end
  end

  assign det_sync = stage2;
  assign change   = stage2 ^ prev;

endmodule

// File: rtl/ci_slot_rst_seq.sv
module ci_slot_rst_seq
  import ci_slot_pkg::*;
#(
  parameter int RST_CYCLES     = 16,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic card_rdy,
  output logic slot_rst,
  output logic busy
);

  localparam int MAX_CNT = (RST_CYCLES > TIMEOUT_CYCLES) ? RST_CYCLES : TIMEOUT_CYCLES;
  localparam int CW      = $clog2(MAX_CNT + 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RST_CYCLES - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TIMEOUT_CYCLES - 1);

  seq_state_e      state;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state <= SEQ_PULSE;
            cnt   <= '0;
          end
        end
        SEQ_PULSE: begin
          if (cnt == RST_LAST) begin
            state <= SEQ_WAIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_WAIT: begin
          if (card_rdy || cnt == TMO_LAST) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= SEQ_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign slot_rst = (state == SEQ_PULSE);
  assign busy     = (state != SEQ_IDLE);

endmodule

// File: rtl/ci_irq_ctrl.sv
module ci_irq_ctrl #(
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] change,
  input  logic             en_wr,
  input  logic [NSLOT-1:0] en_wdata,
  input  logic             ack,
  output logic [NSLOT-1:0] pend,
  output logic [NSLOT-1:0] en,
  output logic             irq_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
    end else begin
      if (en_wr) en <= en_wdata;
      for (int s = 0; s < NSLOT; s++) begin
        if (change[s])  pend[s] <= 1'b1;
        else if (ack)   pend[s] <= 1'b0;
      end
    end
  end

  assign irq_n = ~|(pend & en);

endmodule

// File: rtl/ci_dual_slot_regs.sv
module ci_dual_slot_regs
  import ci_slot_pkg::*;
#(
  parameter int          RST_CYCLES     = 16,
  parameter int          TIMEOUT_CYCLES = 64,
  parameter logic [7:0]  REVISION       = 8'h21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [1:0]  card_det_n,
  input  logic [1:0]  card_rdy,
  input  logic [7:0]  card_rdata,
  output logic [1:0]  slot_rst,
  output logic [1:0]  ts_route,
  output logic [1:0]  ts_out_en,
  output logic [1:0]  tuner_rst_n,
  output logic [14:0] card_addr,
  output logic        card_sel,
  output logic        card_io_space,
  output logic        card_wr,
  output logic        card_rd,
  output logic [7:0]  card_wdata,
  output logic        irq_n
);

  localparam int NSLOT = SLOT_COUNT;

  // decoded register events
  logic wr_irq, wr_ctl2, wr_lo, wr_hi, wr_ctl;
  logic irq_ack;

  assign wr_irq  = reg_wr && (reg_addr == IDX_IRQ);
  assign wr_ctl2 = reg_wr && (reg_addr == IDX_CTL2);
  assign wr_lo   = reg_wr && (reg_addr == IDX_ADDR_LO);
  assign wr_hi   = reg_wr && (reg_addr == IDX_ADDR_HI);
  assign wr_ctl  = reg_wr && (reg_addr == IDX_CTL);
  assign irq_ack = reg_rd && (reg_addr == IDX_IRQ);

  // per-slot internal events, named for the checker
  logic [NSLOT-1:0] seq_start;
  logic [NSLOT-1:0] busy;
  logic [NSLOT-1:0] det_sync;
  logic [NSLOT-1:0] det_change;
  logic [NSLOT-1:0] irq_pend;
  logic [NSLOT-1:0] irq_en;
  logic [NSLOT-1:0] en_wdata;

  // stored fields
  logic             sel_q, space_q;
  logic [NSLOT-1:0] route_q, tsen_q, tuner_q;
  logic [6:0]       addr_lo_q, addr_hi_q;

  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_slot
      assign seq_start[s] = wr_ctl && reg_wdata[rst_bit(s)];
      assign en_wdata[s]  = reg_wdata[irq_en_bit(s)];

      ci_det_sync u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .det_n    (card_det_n[s]),
        .det_sync (det_sync[s]),
        .change   (det_change[s])
      );

      ci_slot_rst_seq #(
        .RST_CYCLES     (RST_CYCLES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
      ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (seq_start[s]),
        .card_rdy (card_rdy[s]),
        .slot_rst (slot_rst[s]),
        .busy     (busy[s])
      );
    end
  endgenerate

  ci_irq_ctrl #(.NSLOT(NSLOT)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .change   (det_change),
    .en_wr    (wr_irq),
    .en_wdata (en_wdata),
    .ack      (irq_ack),
    .pend     (irq_pend),
    .en       (irq_en),
    .irq_n    (irq_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      space_q   <= 1'b0;
      route_q   <= '0;
      tsen_q    <= '0;
      tuner_q   <= '0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
    end else begin
      if (wr_ctl) begin
        sel_q   <= reg_wdata[7];
        space_q <= reg_wdata[6];
        for (int k = 0; k < NSLOT; k++) route_q[k] <= reg_wdata[route_bit(k)];
      end
      if (wr_ctl2) begin
        for (int k = 0; k < NSLOT; k++) begin
          tsen_q[k]  <= reg_wdata[tsen_bit(k)];
          tuner_q[k] <= reg_wdata[tuner_bit(k)];
        end
      end
      if (wr_lo) addr_lo_q <= reg_wdata[7:1];
      if (wr_hi) addr_hi_q <= reg_wdata[6:0];
    end
  end

  // read words
  logic [7:0] rd_irq, rd_ctl, rd_ctl2;

  always_comb begin
    rd_irq  = '0;
    rd_ctl  = '0;
    rd_ctl2 = '0;
    rd_ctl[7] = sel_q;
    rd_ctl[6] = space_q;
    for (int k = 0; k < NSLOT; k++) begin
      rd_irq[irq_pend_bit(k)] = irq_pend[k];
      rd_irq[irq_en_bit(k)]   = irq_en[k];
      rd_ctl[rst_bit(k)]      = busy[k];
      rd_ctl[route_bit(k)]    = route_q[k];
      rd_ctl[det_bit(k)]      = det_sync[k];
      rd_ctl2[tsen_bit(k)]    = tsen_q[k];
      rd_ctl2[tuner_bit(k)]   = tuner_q[k];
    end
  end

  always_comb begin
    case (reg_addr)
      IDX_IRQ:     reg_rdata = rd_irq;
      IDX_CTL2:    reg_rdata = rd_ctl2;
      IDX_ADDR_LO: reg_rdata = {addr_lo_q, 1'b0};
      IDX_ADDR_HI: reg_rdata = {1'b0, addr_hi_q};
      IDX_DATA:    reg_rdata = card_rdata;
      IDX_CTL:     reg_rdata = rd_ctl;
      IDX_REV:     reg_rdata = REVISION;
      default:     reg_rdata = 8'h00;
    endcase
  end

  // card side
  assign card_addr     = join_card_addr(addr_lo_q, addr_hi_q);
  assign card_sel      = sel_q;
  assign card_io_space = space_q;
  assign card_wr       = reg_wr && (reg_addr == IDX_DATA);
  assign card_rd       = reg_rd && (reg_addr == IDX_DATA);
  assign card_wdata    = reg_wdata;
  assign ts_route      = route_q;
  assign ts_out_en     = tsen_q;
  assign tuner_rst_n   = tuner_q;

endmodule

// File: rtl/ci_dual_slot_regs_chk.sv
module ci_dual_slot_regs_chk #(
  parameter int NSLOT          = 2,
  parameter int TIMEOUT_CYCLES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSLOT-1:0] slot_rst,
  input logic [NSLOT-1:0] busy,
  input logic [NSLOT-1:0] seq_start,
  input logic [NSLOT-1:0] det_change,
  input logic [NSLOT-1:0] irq_pend,
  input logic [NSLOT-1:0] irq_en,
  input logic             irq_ack,
  input logic             irq_n
);

  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_chk
      int unsigned wait_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       wait_cnt <= 0;
        else if (busy[s] && !slot_rst[s]) wait_cnt <= wait_cnt + 1;
        else                              wait_cnt <= 0;
      end

      p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start[s] && !busy[s]) |=> slot_rst[s])
        else $error("R4: accepted start did not open a reset pulse");

      p_rst_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_rst[s] |-> busy[s])
        else $error("R4: reset pulse without busy");

      p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[s] && !slot_rst[s]) |=> !slot_rst[s])
        else $error("R6: wait phase fell back into a pulse");

      p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[s] && !slot_rst[s]) |-> (wait_cnt < TIMEOUT_CYCLES))
        else $error("R5: wait phase outlasted its timeout");

      p_change_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        det_change[s] |=> irq_pend[s])
        else $error("R9: detect change did not set pending");

      p_change_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        det_change[s] |=> (!irq_en[s] || !irq_n))
        else $error("R9: enabled change did not pull irq_n low");

      p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !det_change[s]) |=> !irq_pend[s])
        else $error("R10: acknowledge did not clear pending");
    end
  endgenerate

endmodule

bind ci_dual_slot_regs ci_dual_slot_regs_chk #(
  .NSLOT          (NSLOT),
  .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_rst   (slot_rst),
  .busy       (busy),
  .seq_start  (seq_start),
  .det_change (det_change),
  .irq_pend   (irq_pend),
  .irq_en     (irq_en),
  .irq_ack    (irq_ack),
  .irq_n      (irq_n)
);

// File: tb/ci_dual_slot_regs_tb.sv
module ci_dual_slot_regs_tb;

  localparam int         CLK_PERIOD = 10;
  localparam int         RST_C      = 6;
  localparam int         TMO_C      = 12;
  localparam logic [7:0] REV        = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [1:0]  card_det_n = 2'b11;
  logic [1:0]  card_rdy = 2'b11;
  logic [7:0]  card_rdata = 8'h3C;
  logic [1:0]  slot_rst, ts_route, ts_out_en, tuner_rst_n;
  logic [14:0] card_addr;
  logic        card_sel, card_io_space, card_wr, card_rd, irq_n;
  logic [7:0]  card_wdata;

  ci_dual_slot_regs #(
    .RST_CYCLES(RST_C), .TIMEOUT_CYCLES(TMO_C), .REVISION(REV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_det_n(card_det_n),
    .card_rdy(card_rdy), .card_rdata(card_rdata), .slot_rst(slot_rst),
    .ts_route(ts_route), .ts_out_en(ts_out_en), .tuner_rst_n(tuner_rst_n),
    .card_addr(card_addr), .card_sel(card_sel), .card_io_space(card_io_space),
    .card_wr(card_wr), .card_rd(card_rd), .card_wdata(card_wdata), .irq_n(irq_n)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit [1:0] m_d1, m_d2, m_d3;      // detect history, newest first
  bit [1:0] m_pend, m_en;
  int       m_phase[2];             // 0 idle, 1 pulse, 2 waiting
  int       m_left[2];
  int       m_wait[2];
  bit       m_sel, m_space;
  bit [1:0] m_route, m_tsen, m_tun;
  bit [7:0] m_lo;
  bit [6:0] m_hi;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_d1 = 2'b11; m_d2 = 2'b11; m_d3 = 2'b11;
      m_pend = 0; m_en = 0;
      for (int i = 0; i < 2; i++) begin m_phase[i] = 0; m_left[i] = 0; m_wait[i] = 0; end
      m_sel = 0; m_space = 0; m_route = 0; m_tsen = 0; m_tun = 0; m_lo = 0; m_hi = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (m_d2[i] != m_d3[i]) m_pend[i] = 1'b1;
        else if (reg_rd && reg_addr == 4'h0) m_pend[i] = 1'b0;
        case (m_phase[i])
          0: if (reg_wr && reg_addr == 4'h7 && reg_wdata[5 - i]) begin
               m_phase[i] = 1; m_left[i] = RST_C;
             end
          1: begin
               m_left[i] = m_left[i] - 1;
               if (m_left[i] == 0) begin m_phase[i] = 2; m_wait[i] = 0; end
             end
          default: begin
               if (card_rdy[i]) m_phase[i] = 0;
               else if (m_wait[i] == TMO_C - 1) m_phase[i] = 0;
               else m_wait[i] = m_wait[i] + 1;
             end
        endcase
      end
      m_d3 = m_d2; m_d2 = m_d1; m_d1 = card_det_n;
      if (reg_wr) begin
        case (reg_addr)
          4'h0: begin m_en[0] = reg_wdata[6]; m_en[1] = reg_wdata[2]; end
          4'h1: begin
                  m_tsen[0] = reg_wdata[4]; m_tsen[1] = reg_wdata[5];
                  m_tun[0]  = reg_wdata[3]; m_tun[1]  = reg_wdata[2];
                end
          4'h4: m_lo = reg_wdata & 8'hFE;
          4'h5: m_hi = reg_wdata[6:0];
          4'h7: begin
                  m_sel = reg_wdata[7]; m_space = reg_wdata[6];
                  m_route[0] = reg_wdata[3]; m_route[1] = reg_wdata[2];
                end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    logic [7:0] v;
    v = 8'h00;
    case (a)
      4'h0: begin
              if (m_pend[0]) v = v | 8'h80;
              if (m_en[0])   v = v | 8'h40;
              if (m_pend[1]) v = v | 8'h08;
              if (m_en[1])   v = v | 8'h04;
            end
      4'h1: v = {2'b00, m_tsen[1], m_tsen[0], m_tun[0], m_tun[1], 2'b00};
      4'h4: v = m_lo;
      4'h5: v = {1'b0, m_hi};
      4'h6: v = card_rdata;
      4'h7: v = {m_sel, m_space, m_phase[0] != 0, m_phase[1] != 0,
                 m_route[0], m_route[1], m_d2[0], m_d2[1]};
      4'hF: v = REV;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    case (a)
      4'h0: return "R10 irq register";
      4'h1: return "R11 bus control 2";
      4'h4, 4'h5: return "R2 address register";
      4'h6: return "R3 data register";
      4'h7: return "R8 bus control";
      4'hF: return "R12 revision";
      default: return "R12 unused index";
    endcase
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rd_tag(reg_addr), reg_rdata, exp_rd(reg_addr));
      chk("R4 slot_rst", slot_rst, {m_phase[1] == 1, m_phase[0] == 1});
      chk("R9 irq_n", irq_n, !((m_pend[0] && m_en[0]) || (m_pend[1] && m_en[1])));
      chk("R7 ts_route", ts_route, m_route);
      chk("R11 ts_out_en", ts_out_en, m_tsen);
      chk("R11 tuner_rst_n", tuner_rst_n, m_tun);
      chk("R2 card_addr", card_addr, {m_hi, m_lo});
      chk("R3 card_sel", card_sel, m_sel);
      chk("R3 card_io_space", card_io_space, m_space);
      chk("R3 card_wr", card_wr, reg_wr && reg_addr == 4'h6);
      chk("R3 card_rd", card_rd, reg_rd && reg_addr == 4'h6);
      chk("R3 card_wdata", card_wdata, reg_wdata);
    end
  end

  // busy / pulse length monitor on bus control reads
  int mon_busy0, mon_busy1, mon_rst0, mon_rst1;
  always @(negedge clk) begin
    if (rst_n && reg_addr == 4'h7) begin
      if (reg_rdata[5]) mon_busy0++;
      if (reg_rdata[4]) mon_busy1++;
      if (slot_rst[0])  mon_rst0++;
      if (slot_rst[1])  mon_rst1++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    d = reg_rdata;
    @(posedge clk); #2;
    reg_rd = 1'b0;
  endtask

  logic [7:0] rv;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 slot_rst", slot_rst, 2'b00);
    chk("R1 irq_n", irq_n, 1'b1);
    chk("R1 tuner_rst_n", tuner_rst_n, 2'b00);
    chk("R1 ts_out_en", ts_out_en, 2'b00);
    chk("R1 ts_route", ts_route, 2'b00);
    do_rd(4'h7, rv); chk("R1 bus control", rv, 8'h03);
    do_rd(4'h0, rv); chk("R1 irq register", rv, 8'h00);

    // R12 revision and unused indices
    do_rd(4'hF, rv); chk("R12 revision", rv, REV);
    do_rd(4'h9, rv); chk("R12 unused 0x9", rv, 8'h00);
    do_rd(4'h2, rv); chk("R12 unused 0x2", rv, 8'h00);

    // R2 address split
    do_wr(4'h4, 8'hAB);
    do_wr(4'h5, 8'hFF);
    chk("R2 card_addr", card_addr, 15'h7FAA);
    do_rd(4'h4, rv); chk("R2 low readback", rv, 8'hAA);
    do_rd(4'h5, rv); chk("R2 high readback", rv, 8'h7F);
    do_wr(4'h4, 8'h03);
    do_wr(4'h5, 8'h12);
    chk("R2 card_addr second", card_addr, 15'h1202);

    // R11 bus control 2
    do_wr(4'h1, 8'hFF);
    do_rd(4'h1, rv); chk("R11 readback all", rv, 8'h3C);
    chk("R11 tuner all", tuner_rst_n, 2'b11);
    do_wr(4'h1, 8'h18);
    chk("R11 ts_out_en slot0", ts_out_en, 2'b01);
    chk("R11 tuner slot0", tuner_rst_n, 2'b01);

    // R7 / R3 control fields and data access
    do_wr(4'h7, 8'hC4);
    chk("R7 ts_route slot1", ts_route, 2'b10);
    chk("R3 card_sel", card_sel, 1'b1);
    chk("R3 card_io_space", card_io_space, 1'b1);
    do_wr(4'h6, 8'h5E);
    card_rdata = 8'hC3;
    do_rd(4'h6, rv); chk("R3 data read", rv, 8'hC3);
    do_wr(4'h7, 8'h08);
    chk("R7 ts_route slot0", ts_route, 2'b01);
    chk("R3 attribute space", card_io_space, 1'b0);

    // R4 / R5 slot 0 reset with ready already high
    card_rdy = 2'b11;
    mon_busy0 = 0; mon_rst0 = 0;
    do_wr(4'h7, 8'h28);
    idle(RST_C + 4);
    chk("R4 slot0 pulse length", mon_rst0, RST_C);
    chk("R5 slot0 busy with ready", mon_busy0, RST_C + 1);

    // R5 / R6 slot 1 reset timing out, with restart and abort attempts
    card_rdy = 2'b01;
    mon_busy1 = 0; mon_rst1 = 0;
    do_wr(4'h7, 8'h18);
    idle(2);
    do_wr(4'h7, 8'h18);
    do_wr(4'h7, 8'h08);
    idle(RST_C + TMO_C + 4);
    chk("R4 slot1 pulse length", mon_rst1, RST_C);
    chk("R6 R5 slot1 busy until timeout", mon_busy1, RST_C + TMO_C);
    card_rdy = 2'b11;

    // R9 interrupt on slot 0 detect change
    do_wr(4'h0, 8'h44);
    card_det_n[0] = 1'b0;
    idle(3);
    chk("R9 irq_n low", irq_n, 1'b0);
    do_rd(4'h0, rv); chk("R10 irq register pending0", rv, 8'hC4);
    chk("R10 irq_n after ack", irq_n, 1'b1);

    // R10 change arriving with the acknowledge
    card_det_n[1] = 1'b0;
    idle(2);
    do_rd(4'h0, rv); chk("R10 read during change", rv, 8'h44);
    chk("R10 change wins over ack", irq_n, 1'b0);
    do_rd(4'h0, rv); chk("R10 pending1 kept", rv, 8'h4C);
    chk("R10 cleared", irq_n, 1'b1);

    // R8 detect bits read-only
    do_wr(4'h7, 8'hC7);
    do_rd(4'h7, rv); chk("R8 detect bits unaffected", rv, 8'hC4);

    // R9 disabled enables keep irq_n high
    do_wr(4'h0, 8'h00);
    card_det_n = 2'b11;
    idle(4);
    chk("R9 disabled irq_n", irq_n, 1'b1);
    do_rd(4'h0, rv); chk("R9 pending without enable", rv, 8'h88);
    do_rd(4'h7, rv); chk("R8 detect released", rv, 8'hC7);

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule